// File: doc/BRIEF.md
# Fiber Link Signal Presence and Remote Fault Monitor

This block watches the recovered serial receive stream of a 100 Mb/s fiber port that has no optical signal-detect input. It infers that light is present from a long unbroken run of received ones. It also recognises the idle code a far partner sends to report a fault: a run of exactly 84 ones closed by a single zero. After three such codes arrive in a row, it treats the remote fault as confirmed.

A confirmed fault sets a sticky status bit that stays at 1 until management reads it. The fault also raises a flag that tells the MII datapath to ignore traffic in both directions. When the local receiver sees no signal and the link is still down, the block asks the transmit path to send the fault idle code. Both fault generation and fault detection depend on an enable input.

The receive bits arrive with a one-cycle strobe, `rx_valid`. The stream cannot be stalled, so the block never applies back-pressure and has no ready output: every strobed bit is consumed in its own cycle. Cycles without the strobe carry no data.

Top module: `fx_sigdet_fefi`

## Requirements
- R1: After reset, `sig_det`, `rfault_stat` and `mii_block` are 0.
- R2: `sig_det` goes to 1 one cycle after the strobed bit that completes a run of 65 consecutive ones. It stays 0 while the run is shorter.
- R3: A strobed zero that ends a run of fewer than 65 ones clears `sig_det`. A zero that ends a run of 65 or more leaves it at 1. Every zero restarts the run.
- R4: Any value on `rx_bit` in a cycle with `rx_valid` at 0 has no effect on any output.
- R5: A fault idle code is exactly 84 consecutive ones followed by a zero. A zero that ends a run of any other length counts as a non-fault pattern and resets the count of consecutive fault codes to 0.
- R6: `rfault_stat` becomes 1 one cycle after the zero that ends the third consecutive fault code. It also becomes 1 after the zero of every later consecutive fault code. It stays 0 after only two codes.
- R7: Once set, `rfault_stat` holds at 1 until `stat_rd` is 1. It reads 0 in the cycle after that read.
- R8: If `stat_rd` and a fault confirmation fall in the same cycle, `rfault_stat` stays at 1.
- R9: `mii_block` is 1 from the third consecutive fault code onward. It drops one cycle after the zero that ends a non-fault pattern.
- R10: `tx_fefi_sel` equals `fefi_en & ~sig_det & ~link_up`. It follows `link_up` and `fefi_en` in the same cycle.
- R11: With `fefi_en` at 0, no fault codes are counted, `rfault_stat` is never set, and `mii_block` and `tx_fefi_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Strobe marking a recovered receive bit |
| rx_bit | input | 1 | Recovered receive bit, used only when strobed |
| link_up | input | 1 | Link is up |
| fefi_en | input | 1 | Enables fault code generation and detection |
| stat_rd | input | 1 | Management read of the status bit (clears it) |
| sig_det | output | 1 | Inferred signal presence |
| rfault_stat | output | 1 | Sticky remote-fault status |
| tx_fefi_sel | output | 1 | Selects fault idle code for transmission |
| mii_block | output | 1 | Tells the MII datapath to ignore traffic |

## Verification
`sig_det`, `rfault_stat` and `mii_block` are registered. Each changes one clock after the edge that samples the strobed bit or the read. `tx_fefi_sel` is combinational in `link_up` and `fefi_en`, and lags `sig_det` by nothing beyond that register. The bench drives every bit or read on a falling edge, removes it at the next falling edge, and samples the outputs there. That is exactly one rising edge after the stimulus. Sweeps over run lengths around 65 and 84 set each expected value from the length arithmetic.

// File: rtl/fx_fefi_pkg.sv
package fx_fefi_pkg;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/fx_ones_run.sv
module fx_ones_run #(
  parameter int unsigned RUN_MAX = 85,
  parameter int unsigned W       = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_valid,
  input  logic         bit_val,
  output logic [W-1:0] run_q
);
  localparam logic [W-1:0] TOP = W'(RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (bit_valid) begin
      if (!bit_val)
        run_q <= '0;
      else if (run_q != TOP)
        run_q <= run_q + 1'b1;
    end
  end

  a_r4_run_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(run_q));

endmodule

// File: rtl/fx_sig_detect.sv
module fx_sig_detect #(
  parameter int unsigned SD_RUN = 65,
  parameter int unsigned W      = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_valid,
  input  logic         bit_val,
  input  logic [W-1:0] run_q,
  output logic         sig_det
);
  localparam logic [W-1:0] LAST = W'(SD_RUN - 1);
  localparam logic [W-1:0] FULL = W'(SD_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sig_det <= 1'b0;
    else if (bit_valid) begin
      if (bit_val && run_q >= LAST)
        sig_det <= 1'b1;
      else if (!bit_val && run_q < FULL)
        sig_det <= 1'b0;
    end
  end

  a_r2_rise_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_det) |-> $past(bit_valid && bit_val));

  a_r3_fall_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sig_det) |-> $past(bit_valid && !bit_val));

  a_r4_sd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(sig_det));

endmodule

// File: rtl/fx_fefi_track.sv
module fx_fefi_track #(
  parameter int unsigned FEFI_ONES = 84,
  parameter int unsigned CONFIRM   = 3,
  parameter int unsigned W         = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_valid,
  input  logic         bit_val,
  input  logic [W-1:0] run_q,
  input  logic         enable,
  input  logic         stat_rd,
  output logic         fault_present,
  output logic         rfault
);
  import fx_fefi_pkg::*;
  localparam int unsigned CW = bits_for(CONFIRM);
  localparam logic [W-1:0]  ONES_W = W'(FEFI_ONES);
  localparam logic [CW-1:0] CONF   = CW'(CONFIRM);
  localparam logic [CW-1:0] CONF_M1 = CW'(CONFIRM - 1);

  logic [CW-1:0] cnt_q;
  logic          zero_end, code_hit, code_miss, confirm_evt;

  assign zero_end    = bit_valid && !bit_val;
  assign code_hit    = zero_end && (run_q == ONES_W) && enable;
  assign code_miss   = zero_end && (run_q != ONES_W);
  assign confirm_evt = code_hit && (cnt_q >= CONF_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!enable || code_miss)
      cnt_q <= '0;
    else if (code_hit && cnt_q != CONF)
      cnt_q <= cnt_q + 1'b1;
  end

  assign fault_present = (cnt_q == CONF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rfault <= 1'b0;
    else if (confirm_evt)
      rfault <= 1'b1;
    else if (stat_rd)
      rfault <= 1'b0;
  end

  a_r6_set_on_code_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfault) |-> $past(bit_valid && !bit_val && enable));

  a_r7_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rfault && !stat_rd) |=> rfault);

  a_r9_fault_on_code_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_present) |-> $past(bit_valid && !bit_val));

  a_r11_off_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !fault_present);

endmodule

// File: rtl/fx_sigdet_fefi.sv
module fx_sigdet_fefi #(
  parameter int unsigned SD_RUN    = 65,
  parameter int unsigned FEFI_ONES = 84,
  parameter int unsigned CONFIRM   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic link_up,
  input  logic fefi_en,
  input  logic stat_rd,
  output logic sig_det,
  output logic rfault_stat,
  output logic tx_fefi_sel,
  output logic mii_block
);
  import fx_fefi_pkg::*;
  localparam int unsigned RUN_MAX = max_u(SD_RUN, FEFI_ONES + 1);
  localparam int unsigned W       = bits_for(RUN_MAX);

  logic [W-1:0] run_q;
  logic         fault_present;

  fx_ones_run #(.RUN_MAX(RUN_MAX), .W(W)) u_run (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_valid), .bit_val(rx_bit), .run_q(run_q));

  fx_sig_detect #(.SD_RUN(SD_RUN), .W(W)) u_sd (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_valid), .bit_val(rx_bit),
    .run_q(run_q), .sig_det(sig_det));

  fx_fefi_track #(.FEFI_ONES(FEFI_ONES), .CONFIRM(CONFIRM), .W(W)) u_fefi (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_valid), .bit_val(rx_bit),
    .run_q(run_q), .enable(fefi_en), .stat_rd(stat_rd),
    .fault_present(fault_present), .rfault(rfault_stat));

  assign mii_block   = fault_present && fefi_en;
  assign tx_fefi_sel = fefi_en && !sig_det && !link_up;

  a_r10_tx_quiet_on_link: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_det && $past(sig_det)) |-> !tx_fefi_sel);

  a_r11_block_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_block) |-> $past(rx_valid && !rx_bit) || $rose(fefi_en));

endmodule

// File: tb/fx_sigdet_fefi_test.sv
module fx_sigdet_fefi_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, link_up = 1'b0, fefi_en = 1'b1, stat_rd = 1'b0;
  logic sig_det, rfault_stat, tx_fefi_sel, mii_block;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  fx_sigdet_fefi uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .link_up(link_up), .fefi_en(fefi_en), .stat_rd(stat_rd),
    .sig_det(sig_det), .rfault_stat(rfault_stat),
    .tx_fefi_sel(tx_fefi_sel), .mii_block(mii_block));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic b, input logic rd);
    @(negedge clk);
    rx_valid = 1'b1; rx_bit = b; stat_rd = rd;
    @(negedge clk);
    rx_valid = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic pattern(input int n);
    for (int i = 0; i < n; i++) send(1'b1, 1'b0);
    send(1'b0, 1'b0);
  endtask

  task automatic clear_all();
    pattern(0);
    pattern(0);
    rd_pulse();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sig_det", sig_det, 1'b0);
    check("R1 rfault_stat", rfault_stat, 1'b0);
    check("R1 mii_block", mii_block, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 tx sel no signal, link down", tx_fefi_sel, 1'b1);

    // R2/R3: sweep run lengths
    for (int len = 0; len <= 90; len++) begin
      clear_all();
      for (int i = 0; i < len; i++) send(1'b1, 1'b0);
      check("R2 sig_det after ones", sig_det, (len >= 65));
      send(1'b0, 1'b0);
      check("R3 sig_det after closing zero", sig_det, (len >= 65));
      send(1'b0, 1'b0);
      check("R3 sig_det after second zero", sig_det, 1'b0);
    end

    // R4: unstrobed bits ignored
    clear_all();
    for (int i = 0; i < 64; i++) send(1'b1, 1'b0);
    @(negedge clk); rx_bit = 1'b1;
    repeat (10) @(negedge clk);
    check("R4 sig_det unchanged by unstrobed ones", sig_det, 1'b0);
    send(1'b1, 1'b0);
    check("R4 strobed 65th one", sig_det, 1'b1);
    @(negedge clk); rx_bit = 1'b0;
    repeat (10) @(negedge clk);
    check("R4 sig_det unchanged by unstrobed zero", sig_det, 1'b1);

    // R10: transmit select
    check("R10 signal present", tx_fefi_sel, 1'b0);
    clear_all();
    check("R10 no signal", tx_fefi_sel, 1'b1);
    link_up = 1'b1; #1;
    check("R10 link up", tx_fefi_sel, 1'b0);
    link_up = 1'b0; fefi_en = 1'b0; #1;
    check("R10 disabled", tx_fefi_sel, 1'b0);
    fefi_en = 1'b1;

    // R5/R6/R9: code length sweep, three repeats each
    for (int len = 80; len <= 88; len++) begin
      clear_all();
      for (int k = 0; k < 3; k++) pattern(len);
      check("R5 R6 rfault after three codes", rfault_stat, (len == 84));
      check("R9 mii_block after three codes", mii_block, (len == 84));
    end

    // R6: two codes not enough; R5 interruption restarts count
    clear_all();
    pattern(84); pattern(84);
    check("R6 two codes", rfault_stat, 1'b0);
    pattern(10);
    pattern(84);
    check("R5 interrupted sequence", rfault_stat, 1'b0);
    pattern(84);
    check("R5 only two consecutive", rfault_stat, 1'b0);
    pattern(84);
    check("R6 third consecutive", rfault_stat, 1'b1);
    check("R9 block on fault", mii_block, 1'b1);

    // R7: hold until read
    repeat (20) @(negedge clk);
    check("R7 held without read", rfault_stat, 1'b1);
    rd_pulse();
    check("R7 cleared by read", rfault_stat, 1'b0);
    check("R9 block remains after read", mii_block, 1'b1);
    pattern(84);
    check("R6 later consecutive code sets again", rfault_stat, 1'b1);

    // R8: read and confirmation same cycle
    rd_pulse();
    for (int i = 0; i < 84; i++) send(1'b1, 1'b0);
    send(1'b0, 1'b1);
    check("R8 set wins over read", rfault_stat, 1'b1);
    rd_pulse();
    check("R8 later read clears", rfault_stat, 1'b0);

    // R9: non-fault pattern releases block
    pattern(30);
    check("R9 block dropped", mii_block, 1'b0);

    // R11: disabled
    clear_all();
    fefi_en = 1'b0;
    for (int k = 0; k < 4; k++) pattern(84);
    check("R11 no status when disabled", rfault_stat, 1'b0);
    check("R11 no block when disabled", mii_block, 1'b0);
    check("R11 no tx select when disabled", tx_fefi_sel, 1'b0);
    fefi_en = 1'b1;
    @(negedge clk);
    check("R11 enable does not revive count", mii_block, 1'b0);
    pattern(84);
    check("R11 counting restarts from zero", rfault_stat, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule